// File: doc/BRIEF.md
# Printer Port Register Slave

This block is the register file of a byte-wide compatibility printer port, seen from the bus. A host reads and writes three registers: an output data latch, a status register and a control register. The block plays the printer's part in the handshake. When the host pulses its strobe control bit while select and init are set, the block sends the latched byte out on a transmit pulse and clears busy. It raises a level interrupt when the strobe is released with interrupts enabled. Each status read moves ack and busy one step through an acknowledge sequence.

An access is one cycle long: `acc_en` with `acc_wr` high is a write, and `acc_en` with `acc_wr` low is a read. Read data is combinational from the current state. All side effects take hold at the clock edge that ends the access. Only the low three address bits are decoded.

Top module: `pport_regs`

## Requirements
- R1: After synchronous reset, a data read returns 0xFF, a status read returns 0xD9, a control read returns 0xCC, `irq` is 0 and `tx_valid` is 0.
- R2: Reads at offsets 3 to 7 return 0xFF. Writes at those offsets change no register.
- R3: A write at offset 2 stores the written byte with bits 7 and 6 forced to 1. A read at offset 2 returns the stored value.
- R4: A read at offset 0 returns the output latch (the last byte written at offset 0) when control bit 5 (direction) is 0. When bit 5 is 1 it returns the input latch, which holds 0xFF.
- R5: A control write with bit 2 (init) equal to 0 loads status with 0xD8.
- R6: A control write with init=1, select (bit 3)=1 and strobe (bit 0)=1 clears status bit 7 (busy complement). If the stored strobe bit was 0 before the write, `tx_valid` pulses in the cycle after the write, with `tx_data` equal to the output latch.
- R7: No byte is emitted by a control write that has select=0 or init=0, nor by a strobe-set write when the stored strobe bit was already 1.
- R8: A control write with init=1, select=1 and strobe=0 sets interrupt-pending, but only if the previously stored control bit 4 (interrupt enable) was 1. `irq` follows pending in the cycle after the access.
- R9: A status read returns the status held before the read and clears interrupt-pending. `irq` is 0 in the following cycle.
- R10: On a status read with status bit 7 = 0 and stored strobe = 0, status bit 6 (ack) is cleared if it was 1. If it was 0, bits 6 and 7 are both set. In all other cases the read leaves status unchanged.
- R11: `tx_valid` is high for one cycle per emitted byte. There is no backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level interrupt request |
| tx_valid | output | 1 | One-cycle pulse: byte emitted |
| tx_data | output | 8 | Emitted byte |

## Verification
The bench targets the strobe edge. A design that tested the new strobe level instead of the edge would emit repeated bytes when strobe-set writes repeat. The bench also checks that the enable gate reads the old control value: a design using the newly written interrupt-enable bit would raise `irq` from the same write that turns it on. It walks the ack/busy sequence through the full acknowledge loop. A design that skipped the stored-strobe gate, or that stepped status before returning it, would return a shifted status. Random traffic over all eight offsets also exercises unhandled offsets and the direction-dependent data read.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        OFS_DATA = 3'd0,
        OFS_STAT = 3'd1,
        OFS_CTRL = 3'd2
    } ofs_e;

    typedef struct packed {
        logic       n_busy;
        logic       ack;
        logic       paper_out;
        logic       online;
        logic       n_fault;
        logic [1:0] spare;
        logic       timeout;
    } stat_t;

    typedef struct packed {
        logic [1:0] fixed_hi;
        logic       dir_in;
        logic       irq_en;
        logic       sel;
        logic       init;
        logic       autolf;
        logic       strobe;
    } ctrl_t;

    localparam logic [DW-1:0] STAT_RST  = 8'hD9;
    localparam logic [DW-1:0] STAT_INIT = 8'hD8;
    localparam logic [DW-1:0] CTRL_RST  = 8'hCC;
    localparam logic [DW-1:0] CTRL_HI   = 8'hC0;
    localparam logic [DW-1:0] ALL_ONES  = 8'hFF;

    // Acknowledge-sequence step applied by a status read
    function automatic stat_t stat_step(stat_t s, logic strobe_q);
        stat_t n;
        n = s;
        if (!s.n_busy && !strobe_q) begin
            if (s.ack) begin
                n.ack = 1'b0;
            end else begin
                n.ack    = 1'b1;
                n.n_busy = 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic          data_wr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] dout_q,
    output logic          init_low,
    output logic          busy_clr,
    output logic          pend_set,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data
);
    ctrl_t nv;
    logic  sel_ok;
    logic  emit;

    always_comb begin
        nv       = ctrl_t'(wdata | CTRL_HI);
        init_low = ctrl_wr && !nv.init;
        sel_ok   = ctrl_wr && nv.init && nv.sel;
        busy_clr = sel_ok && nv.strobe;
        emit     = busy_clr && !ctrl_q.strobe;
        pend_set = sel_ok && !nv.strobe && ctrl_q.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= ctrl_t'(CTRL_RST);
            dout_q   <= ALL_ONES;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= nv;
            if (data_wr) dout_q <= wdata;
            tx_valid <= emit;
            if (emit) tx_data <= dout_q;
        end
    end

    // R11
    tx_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> !tx_valid);

    // R6
    tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
        emit |=> (tx_valid && ctrl_q.strobe && ctrl_q.sel));
endmodule

// File: rtl/pport_status.sv
module pport_status
    import pport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stat_rd,
    input  logic  strobe_q,
    input  logic  init_low,
    input  logic  busy_clr,
    input  logic  pend_set,
    output stat_t stat_q,
    output logic  irq
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= stat_t'(STAT_RST);
            pend_q <= 1'b0;
        end else begin
            if (init_low) begin
                stat_q <= stat_t'(STAT_INIT);
            end else if (busy_clr) begin
                stat_q.n_busy <= 1'b0;
            end else if (stat_rd) begin
                stat_q <= stat_step(stat_q, strobe_q);
            end
            if (stat_rd)       pend_q <= 1'b0;
            else if (pend_set) pend_q <= 1'b1;
        end
    end

    assign irq = pend_q;

    // R9
    rd_ack_chk: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> !irq);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(pend_set));

    // R5
    init_load_chk: assert property (@(posedge clk) disable iff (rst)
        init_low |=> (stat_q == stat_t'(STAT_INIT)));
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic          irq,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data
);
    localparam logic [DW-1:0] IN_LATCH = ALL_ONES;

    ctrl_t         ctrl_q;
    stat_t         stat_q;
    logic [DW-1:0] dout_q;
    logic          init_low, busy_clr, pend_set;
    logic          ctrl_wr, data_wr, stat_rd;

    assign ctrl_wr = acc_en &&  acc_wr && (acc_addr == OFS_CTRL);
    assign data_wr = acc_en &&  acc_wr && (acc_addr == OFS_DATA);
    assign stat_rd = acc_en && !acc_wr && (acc_addr == OFS_STAT);

    pport_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .data_wr  (data_wr),
        .wdata    (acc_wdata),
        .ctrl_q   (ctrl_q),
        .dout_q   (dout_q),
        .init_low (init_low),
        .busy_clr (busy_clr),
        .pend_set (pend_set),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    pport_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (stat_rd),
        .strobe_q (ctrl_q.strobe),
        .init_low (init_low),
        .busy_clr (busy_clr),
        .pend_set (pend_set),
        .stat_q   (stat_q),
        .irq      (irq)
    );

    always_comb begin
        unique case (acc_addr)
            OFS_DATA: acc_rdata = ctrl_q.dir_in ? IN_LATCH : dout_q;
            OFS_STAT: acc_rdata = stat_q;
            OFS_CTRL: acc_rdata = ctrl_q;
            default:  acc_rdata = ALL_ONES;
        endcase
    end

    // R3
    ctrl_hi_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q[7:6] == 2'b11));
endmodule

// File: tb/tb_pport_regs.sv
module tb_pport_regs;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_en, acc_wr;
    logic [2:0] acc_addr;
    logic [7:0] acc_wdata;
    logic [7:0] acc_rdata;
    logic       irq, tx_valid;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_dout, m_stat, m_ctrl;
    logic       m_pend, m_emit;
    logic [7:0] m_txb;

    always #4 clk = ~clk;

    pport_regs dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl[5] ? 8'hFF : m_dout;
            3'd1: return m_stat;
            3'd2: return m_ctrl;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_wr(logic [2:0] a, logic [7:0] v);
        logic [7:0] nv;
        m_emit = 1'b0;
        if (a == 3'd0) m_dout = v;
        if (a == 3'd2) begin
            nv = v | 8'hC0;
            if (!nv[2]) m_stat = 8'hD8;
            else if (nv[3]) begin
                if (nv[0]) begin
                    m_stat[7] = 1'b0;
                    if (!m_ctrl[0]) begin m_emit = 1'b1; m_txb = m_dout; end
                end else if (m_ctrl[4]) m_pend = 1'b1;
            end
            m_ctrl = nv;
        end
    endtask

    task automatic model_rd(logic [2:0] a);
        if (a == 3'd1) begin
            m_pend = 1'b0;
            if (!m_stat[7] && !m_ctrl[0]) begin
                if (m_stat[6]) m_stat[6] = 1'b0;
                else m_stat[7:6] = 2'b11;
            end
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] v);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = v;
        model_wr(a, v);
        @(posedge clk); #1;
        acc_en = 1'b0;
        @(negedge clk);
        chk("R6/R7 tx_valid", {7'd0, tx_valid}, {7'd0, m_emit});
        if (m_emit) chk("R6 tx_data", tx_data, m_txb);
        chk("R8 irq", {7'd0, irq}, {7'd0, m_pend});
    endtask

    task automatic rd(logic [2:0] a, string tag);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1;
        chk(tag, acc_rdata, exp_rd(a));
        model_rd(a);
        @(posedge clk); #1;
        acc_en = 1'b0;
        @(negedge clk);
        chk("R9 irq after read", {7'd0, irq}, {7'd0, m_pend});
        chk("R11 tx idle", {7'd0, tx_valid}, 8'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        acc_en = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;
        rst = 1'b1;
        m_dout = 8'hFF; m_stat = 8'hD9; m_ctrl = 8'hCC; m_pend = 0; m_emit = 0; m_txb = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
        rd(3'd0, "R1 data");
        rd(3'd2, "R1 control");
        rd(3'd1, "R1 status");
        // R2: unhandled offsets read 0xFF, writes ignored
        for (int i = 3; i < 8; i++) begin
            wr(3'(i), 8'h00);
            rd(3'(i), "R2 unhandled");
        end
        rd(3'd2, "R2 control untouched");
        // R3 / R4
        wr(3'd0, 8'h41);
        rd(3'd0, "R4 output latch");
        wr(3'd2, 8'h2C);
        rd(3'd2, "R3 forced bits");
        rd(3'd0, "R4 input latch");
        // R6 / R10 handshake
        wr(3'd2, 8'h0C);
        wr(3'd2, 8'h0D);
        wr(3'd2, 8'h0D);            // R7 no second emit
        wr(3'd2, 8'h0C);
        rd(3'd1, "R10 busy low");
        rd(3'd1, "R10 ack cleared");
        rd(3'd1, "R10 ack+busy set");
        // R8 enable from previous control
        wr(3'd2, 8'h1C);
        wr(3'd2, 8'h1C);
        rd(3'd1, "R9 status with irq");
        // R7 select low, R5 init low
        wr(3'd2, 8'h04);
        wr(3'd2, 8'h05);
        wr(3'd2, 8'h09);
        rd(3'd1, "R5 init status");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [2:0] a;
            logic [7:0] v;
            a = ($urandom % 2) ? 3'($urandom % 3) : 3'($urandom);
            v = 8'($urandom);
            if ($urandom % 4 != 0) v[3:2] = 2'b11;
            if ($urandom % 2) wr(a, v);
            else rd(a, "R10 random read");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule